// File: doc/BRIEF.md
# Layered Pixel Compositor

This block merges two graphics layers and one video layer into one output pixel, painting them over a background color. Every clock it accepts one pixel from each layer, already aligned to the same screen position. It produces one 24-bit color. Graphics pixels arrive in one of four packed formats. Each is widened to 8 bits per channel with an 8-bit alpha. Each layer is then combined with what lies beneath it, according to its own pixel-alpha mode and an optional whole-layer alpha.

Layers are stacked by a 2-bit rank. A layer with rank 0 or with its enable clear is left out. Layer setup arrives over a small write port with reset defaults. The output is fully pipelined, so a new set of input pixels may be presented every cycle.

Top module: `mix_compositor`

## Requirements
- R1: On the first clock after reset is released, pix_out is 0x000000. Once the pipeline has filled and no writes have occurred, pix_out equals the reset background 0x008080. At reset, every layer is disabled with rank 0, each graphics layer is format 7 in mode 0 with layer alpha 0xFFFF, and the video layer alpha is 0xFFFF.
- R2: A write with cfg_we high updates the setting selected by cfg_addr on that clock edge. The addresses are:
  - Address 0 is layer control. Enables are in bits [2:0] (bit 0 graphics 0, bit 1 graphics 1, bit 2 video). Ranks are 2-bit fields: graphics 0 in [9:8], graphics 1 in [11:10], video in [13:12].
  - Address 1 is the background, in bits [23:0].
  - Addresses 2 and 3 set graphics layers 0 and 1. Format code is in [2:0], mode in [5:4], and the 16-bit layer alpha in [31:16].
  - Address 4 holds the video layer alpha in [31:16].
- R3: Graphics pixels are unpacked by format code. Missing low bits are filled by repeating the channel's top bits.
  - Code 4 is 16-bit R5 G6 B5, from the top channel down, with alpha 0xFF.
  - Code 5 is A1 R5 G5 B5, with alpha 0x00 or 0xFF.
  - Code 6 is A4 R4 G4 B4.
  - Code 7, and any other code, is 32-bit A8 R8 G8 B8.
- R4: Mode 0 ignores the pixel's alpha. Mode 1 blends each channel as (a*src + (255-a)*dst)/255, truncated.
- R5: Modes 2 and 3 blend each channel as src + ((255-a)*dst)/255, truncated, then limited to 255.
- R6: The layer alpha takes effect only when its 16-bit value is not 0xFFFF. It then contributes its upper byte wa. The combined alpha is pa*wa/255, truncated, where pa is the pixel alpha, or 255 in mode 0. wa is 255 when the layer alpha is not in effect.
- R7: A layer with a higher rank is painted on top. At equal rank, the layer with the higher index is on top (graphics 0 < graphics 1 < video).
- R8: A layer whose enable is clear or whose rank is 0 leaves the output unchanged.
- R9: The video pixel is 24-bit R8 G8 B8 with no pixel alpha. It blends with mode 1, using only its layer alpha.
- R10: pix_out reflects the pixels and settings presented 4 clocks earlier, and accepts new pixels every clock.
- R11: The background's three bytes seed the blend in the positions [23:16], [15:8] and [7:0]. No color-space conversion is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 3 | Setting select |
| cfg_wdata | input | 32 | Setting write data |
| gfx_px | input | 64 | Graphics pixels; layer 0 in [31:0], layer 1 in [63:32] |
| vid_px | input | 24 | Video pixel, R8 G8 B8 |
| pix_out | output | 24 | Composited color |

## Verification
The bench covers the following cases, each against values worked out by hand:

- **Bit replication** in the narrow formats. A shift-only expansion would turn 0x8410 into 0x808080 rather than 0x848284.
- **Mode 0** with a zero pixel alpha. A design that honoured the alpha anyway would show the background.
- **Premultiplied overflow.** Without the 255 limit, the blue channel would wrap to a small value.
- **Combined alpha.** A layer alpha of 0x40FF must take effect even though its low byte is 0xFF.
- **Equal ranks.** At equal rank the higher index must win, and rank 0 must hide an enabled layer. Errors here would show the wrong layer or the wrong color.
- **Pipeline depth.** The output is sampled one cycle before and at the expected latency, so an extra or missing register stage shows up.

// File: rtl/mix_pkg.sv
package mix_pkg;

  localparam int PRIO_W = 2;

  localparam logic [2:0] FMT_RGB565   = 3'd4;
  localparam logic [2:0] FMT_ARGB1555 = 3'd5;
  localparam logic [2:0] FMT_ARGB4444 = 3'd6;
  localparam logic [2:0] FMT_ARGB8888 = 3'd7;

  localparam logic [23:0] BG_RESET = 24'h008080;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic       premul;
    logic       vld;
  } lyr_t;

  // Upper byte of the layer alpha, or opaque when the full value is opaque.
  function automatic logic [7:0] win_alpha(input logic [15:0] a16);
    return (a16 == 16'hFFFF) ? 8'hFF : a16[15:8];
  endfunction

  // x*y/255, truncated.
  function automatic logic [7:0] mul_norm(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] p;
    p = (16'(x) * 16'(y)) / 16'd255;
    return p[7:0];
  endfunction

  // One channel of the blend.
  function automatic logic [7:0] blend_ch(input logic [7:0] src, input logic [7:0] dst,
                                          input logic [7:0] a, input logic premul);
    logic [7:0]  inv;
    logic [15:0] pd;
    logic [16:0] sum;
    inv = 8'hFF - a;
    pd  = 16'(inv) * 16'(dst);
    if (premul) begin
      sum = 17'(src) + 17'(pd / 16'd255);
      if (sum > 17'd255) sum = 17'd255;
    end else begin
      sum = (17'(16'(a) * 16'(src)) + 17'(pd)) / 17'd255;
    end
    return sum[7:0];
  endfunction

endpackage

// File: rtl/mix_unpack.sv
module mix_unpack
  import mix_pkg::*;
(
  input  logic [31:0] raw,
  input  logic [2:0]  fmt,
  input  logic [1:0]  mode,
  input  logic [15:0] alpha16,
  input  logic        act,
  output lyr_t        lyr
);

  logic [7:0] pa, r, g, b, pa_eff;

  always_comb begin
    case (fmt)
      FMT_RGB565: begin
        pa = 8'hFF;
        r  = {raw[15:11], raw[15:13]};
        g  = {raw[10:5],  raw[10:9]};
        b  = {raw[4:0],   raw[4:2]};
      end
      FMT_ARGB1555: begin
        pa = {8{raw[15]}};
        r  = {raw[14:10], raw[14:12]};
        g  = {raw[9:5],   raw[9:7]};
        b  = {raw[4:0],   raw[4:2]};
      end
      FMT_ARGB4444: begin
        pa = {raw[15:12], raw[15:12]};
        r  = {raw[11:8],  raw[11:8]};
        g  = {raw[7:4],   raw[7:4]};
        b  = {raw[3:0],   raw[3:0]};
      end
      default: begin
        pa = raw[31:24];
        r  = raw[23:16];
        g  = raw[15:8];
        b  = raw[7:0];
      end
    endcase
    pa_eff     = (mode == 2'd0) ? 8'hFF : pa;
    lyr.a      = mul_norm(pa_eff, win_alpha(alpha16));
    lyr.r      = r;
    lyr.g      = g;
    lyr.b      = b;
    lyr.premul = mode[1];
    lyr.vld    = act;
  end

endmodule

// File: rtl/mix_order.sv
module mix_order
  import mix_pkg::*;
#(
  parameter int N = 3
) (
  input  lyr_t [N-1:0]             lyr_in,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output lyr_t [N-1:0]             slot
);

  // Slot 0 is painted first (bottom); rank key is {priority, index}.
  always_comb begin
    slot = '0;
    for (int i = 0; i < N; i++) begin
      int rank;
      rank = 0;
      for (int j = 0; j < N; j++) begin
        if (lyr_in[j].vld && ((prio[j] < prio[i]) || ((prio[j] == prio[i]) && (j < i))))
          rank = rank + 1;
      end
      if (lyr_in[i].vld) slot[rank] = lyr_in[i];
    end
  end

endmodule

// File: rtl/mix_delay.sv
module mix_delay #(
  parameter int DEPTH = 1,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) sr[k] <= '0;
    end else begin
      sr[0] <= din;
      for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
    end
  end

  assign dout = sr[DEPTH-1];

endmodule

// File: rtl/mix_blend_stage.sv
module mix_blend_stage
  import mix_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [23:0] acc_in,
  input  lyr_t        cur,
  output logic [23:0] acc_out
);

  logic [23:0] mixed;

  always_comb begin
    mixed[23:16] = blend_ch(cur.r, acc_in[23:16], cur.a, cur.premul);
    mixed[15:8]  = blend_ch(cur.g, acc_in[15:8],  cur.a, cur.premul);
    mixed[7:0]   = blend_ch(cur.b, acc_in[7:0],   cur.a, cur.premul);
  end

  always_ff @(posedge clk) begin
    if (rst)          acc_out <= '0;
    else if (cur.vld) acc_out <= mixed;
    else              acc_out <= acc_in;
  end

endmodule

// File: rtl/mix_compositor.sv
module mix_compositor
  import mix_pkg::*;
#(
  parameter int N_GFX = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [$clog2(N_GFX+3)-1:0]  cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  input  logic [N_GFX*32-1:0]         gfx_px,
  input  logic [23:0]                 vid_px,
  output logic [23:0]                 pix_out
);

  localparam int N_LAYERS = N_GFX + 1;
  localparam int ADDR_W   = $clog2(N_GFX + 3);
  localparam int ADDR_GFX = 2;
  localparam int ADDR_VID = 2 + N_GFX;

  logic [N_LAYERS-1:0]             en_q;
  logic [N_LAYERS-1:0][PRIO_W-1:0] prio_q;
  logic [23:0]                     bg_q;
  logic [N_GFX-1:0][2:0]           fmt_q;
  logic [N_GFX-1:0][1:0]           mode_q;
  logic [N_GFX-1:0][15:0]          alpha_q;
  logic [15:0]                     va_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      prio_q <= '0;
      bg_q   <= BG_RESET;
      va_q   <= 16'hFFFF;
      for (int g = 0; g < N_GFX; g++) begin
        fmt_q[g]   <= FMT_ARGB8888;
        mode_q[g]  <= 2'd0;
        alpha_q[g] <= 16'hFFFF;
      end
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_W'(0)) begin
        en_q <= cfg_wdata[N_LAYERS-1:0];
        for (int i = 0; i < N_LAYERS; i++)
          prio_q[i] <= cfg_wdata[8 + PRIO_W*i +: PRIO_W];
      end
      if (cfg_addr == ADDR_W'(1)) bg_q <= cfg_wdata[23:0];
      for (int g = 0; g < N_GFX; g++) begin
        if (cfg_addr == ADDR_W'(ADDR_GFX + g)) begin
          fmt_q[g]   <= cfg_wdata[2:0];
          mode_q[g]  <= cfg_wdata[5:4];
          alpha_q[g] <= cfg_wdata[31:16];
        end
      end
      if (cfg_addr == ADDR_W'(ADDR_VID)) va_q <= cfg_wdata[31:16];
    end
  end

  lyr_t [N_LAYERS-1:0] lyr_c;
  lyr_t [N_LAYERS-1:0] slot_c;

  for (genvar g = 0; g < N_GFX; g++) begin : g_gfx
    mix_unpack u_unpack (
      .raw     (gfx_px[32*g +: 32]),
      .fmt     (fmt_q[g]),
      .mode    (mode_q[g]),
      .alpha16 (alpha_q[g]),
      .act     (en_q[g] && (prio_q[g] != '0)),
      .lyr     (lyr_c[g])
    );
  end

  always_comb begin
    lyr_c[N_LAYERS-1].a      = win_alpha(va_q);
    lyr_c[N_LAYERS-1].r      = vid_px[23:16];
    lyr_c[N_LAYERS-1].g      = vid_px[15:8];
    lyr_c[N_LAYERS-1].b      = vid_px[7:0];
    lyr_c[N_LAYERS-1].premul = 1'b0;
    lyr_c[N_LAYERS-1].vld    = en_q[N_LAYERS-1] && (prio_q[N_LAYERS-1] != '0);
  end

  mix_order #(.N(N_LAYERS)) u_order (
    .lyr_in (lyr_c),
    .prio   (prio_q),
    .slot   (slot_c)
  );

  // Entry stage: background seeds the accumulator.
  logic [23:0] acc0_q;
  always_ff @(posedge clk) begin
    if (rst) acc0_q <= '0;
    else     acc0_q <= bg_q;
  end

  logic [23:0] acc_o [N_LAYERS];

  for (genvar s = 0; s < N_LAYERS; s++) begin : g_stage
    lyr_t        cur;
    logic [23:0] acc_in;
    mix_delay #(.DEPTH(s + 1), .W($bits(lyr_t))) u_dly (
      .clk  (clk),
      .rst  (rst),
      .din  (slot_c[s]),
      .dout (cur)
    );
    if (s == 0) begin : g_first
      assign acc_in = acc0_q;
    end else begin : g_next
      assign acc_in = acc_o[s-1];
    end
    mix_blend_stage u_blend (
      .clk     (clk),
      .rst     (rst),
      .acc_in  (acc_in),
      .cur     (cur),
      .acc_out (acc_o[s])
    );
  end

  assign pix_out = acc_o[N_LAYERS-1];

endmodule

// File: rtl/mix_compositor_chk.sv
module mix_compositor_chk #(
  parameter int N_GFX = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        cfg_we,
  input logic [$clog2(N_GFX+3)-1:0]  cfg_addr,
  input logic [31:0]                 cfg_wdata,
  input logic [N_GFX*32-1:0]         gfx_px,
  input logic [23:0]                 vid_px,
  input logic [23:0]                 pix_out
);

  localparam int N  = N_GFX + 1;
  localparam int AW = $clog2(N_GFX + 3);

  logic [N-1:0]       en_sh;
  logic [N-1:0][1:0]  pr_sh;
  logic [23:0]        bg_sh;
  logic [15:0]        va_sh;
  logic [N_GFX*32-1:0] prev_g;
  logic [23:0]        prev_v;
  logic [3:0]         quiet;
  logic [N-1:0]       act;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_sh  <= '0;
      pr_sh  <= '0;
      bg_sh  <= 24'h008080;
      va_sh  <= 16'hFFFF;
      prev_g <= '0;
      prev_v <= '0;
      quiet  <= '0;
    end else begin
      if (cfg_we && cfg_addr == AW'(0)) begin
        en_sh <= cfg_wdata[N-1:0];
        for (int i = 0; i < N; i++) pr_sh[i] <= cfg_wdata[8 + 2*i +: 2];
      end
      if (cfg_we && cfg_addr == AW'(1)) bg_sh <= cfg_wdata[23:0];
      if (cfg_we && cfg_addr == AW'(2 + N_GFX)) va_sh <= cfg_wdata[31:16];
      prev_g <= gfx_px;
      prev_v <= vid_px;
      if (cfg_we || gfx_px != prev_g || vid_px != prev_v) quiet <= '0;
      else if (quiet != 4'hF)                             quiet <= quiet + 4'd1;
    end
  end

  always_comb
    for (int i = 0; i < N; i++) act[i] = en_sh[i] && (pr_sh[i] != 2'd0);

  // R1
  rst_out_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pix_out == 24'h000000);

  // R10
  steady_out_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 4'd6) |-> $stable(pix_out));

  // R8
  idle_bg_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 4'd6 && act == '0) |-> pix_out == bg_sh);

  // R9
  vid_opaque_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 4'd6 && act == (N'(1) << (N-1)) && va_sh == 16'hFFFF) |-> pix_out == vid_px);

endmodule

bind mix_compositor mix_compositor_chk #(.N_GFX(N_GFX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .gfx_px    (gfx_px),
  .vid_px    (vid_px),
  .pix_out   (pix_out)
);

// File: tb/sim_mix_compositor.sv
module sim_mix_compositor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [63:0] gfx_px = '0;
  logic [23:0] vid_px = '0;
  logic [23:0] pix_out;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mix_compositor u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .gfx_px(gfx_px), .vid_px(vid_px), .pix_out(pix_out)
  );

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%06h exp=%06h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input logic [2:0] en, input logic [1:0] p0,
                                      input logic [1:0] p1, input logic [1:0] pv);
    return {18'd0, pv, p1, p0, 5'd0, en};
  endfunction

  function automatic logic [31:0] gcf(input logic [2:0] fmt, input logic [1:0] mode,
                                      input logic [15:0] a16);
    return {a16, 10'd0, mode, 1'b0, fmt};
  endfunction

  task automatic defaults();
    wr(3'd0, ctl(3'b000, 2'd0, 2'd0, 2'd0));
    wr(3'd1, 32'h0000_8080);
    wr(3'd2, gcf(3'd7, 2'd0, 16'hFFFF));
    wr(3'd3, gcf(3'd7, 2'd0, 16'hFFFF));
    wr(3'd4, 32'hFFFF_0000);
    gfx_px = '0; vid_px = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 output right after reset", pix_out, 24'h000000);
    settle();
    chk("R1 R11 reset background", pix_out, 24'h008080);
  endtask

  task automatic t_formats();
    defaults();
    wr(3'd0, ctl(3'b001, 2'd1, 2'd0, 2'd0));
    wr(3'd2, gcf(3'd4, 2'd0, 16'hFFFF));
    gfx_px[31:0] = 32'h0000_8410; settle();
    chk("R3 R2 rgb565 replication", pix_out, 24'h848284);
    wr(3'd2, gcf(3'd6, 2'd0, 16'hFFFF));
    gfx_px[31:0] = 32'h0000_0ABC; settle();
    chk("R3 R4 argb4444 mode0 ignores alpha", pix_out, 24'hAABBCC);
    wr(3'd2, gcf(3'd5, 2'd1, 16'hFFFF));
    gfx_px[31:0] = 32'h0000_7FFF; settle();
    chk("R3 R4 argb1555 alpha0 coverage", pix_out, 24'h008080);
    gfx_px[31:0] = 32'h0000_FFFF; settle();
    chk("R3 argb1555 alpha1", pix_out, 24'hFFFFFF);
  endtask

  task automatic t_modes();
    defaults();
    wr(3'd0, ctl(3'b001, 2'd1, 2'd0, 2'd0));
    wr(3'd2, gcf(3'd7, 2'd1, 16'hFFFF));
    gfx_px[31:0] = 32'h80FF_0040; settle();
    chk("R4 coverage blend", pix_out, 24'h803F5F);
    wr(3'd2, gcf(3'd7, 2'd2, 16'hFFFF));
    gfx_px[31:0] = 32'h8040_00FF; settle();
    chk("R5 premultiplied with clamp", pix_out, 24'h403FFF);
    wr(3'd2, gcf(3'd7, 2'd3, 16'hFFFF)); settle();
    chk("R5 mode 3 as premultiplied", pix_out, 24'h403FFF);
  endtask

  task automatic t_window();
    defaults();
    wr(3'd0, ctl(3'b001, 2'd1, 2'd0, 2'd0));
    wr(3'd2, gcf(3'd7, 2'd0, 16'h40FF));
    gfx_px[31:0] = 32'h00FF_FFFF; settle();
    chk("R6 layer alpha upper byte", pix_out, 24'h409F9F);
    wr(3'd2, gcf(3'd7, 2'd1, 16'h8000));
    gfx_px[31:0] = 32'h80FF_FFFF; settle();
    chk("R6 combined alpha", pix_out, 24'h409F9F);
  endtask

  task automatic t_priority();
    defaults();
    wr(3'd2, gcf(3'd7, 2'd0, 16'hFFFF));
    wr(3'd3, gcf(3'd7, 2'd0, 16'hFFFF));
    gfx_px = {32'hFF00_00FF, 32'hFFFF_0000};
    wr(3'd0, ctl(3'b011, 2'd1, 2'd2, 2'd0)); settle();
    chk("R7 higher rank on top", pix_out, 24'h0000FF);
    wr(3'd0, ctl(3'b011, 2'd3, 2'd2, 2'd0)); settle();
    chk("R7 swapped ranks", pix_out, 24'hFF0000);
    wr(3'd0, ctl(3'b011, 2'd2, 2'd2, 2'd0)); settle();
    chk("R7 tie goes to higher index", pix_out, 24'h0000FF);
    wr(3'd3, gcf(3'd7, 2'd1, 16'hFFFF));
    gfx_px[63:32] = 32'h8000_00FF;
    wr(3'd0, ctl(3'b011, 2'd1, 2'd2, 2'd0)); settle();
    chk("R7 R4 two-layer stack", pix_out, 24'h7F0080);
  endtask

  task automatic t_inactive();
    defaults();
    gfx_px[31:0] = 32'hFFFF_0000;
    wr(3'd0, ctl(3'b001, 2'd0, 2'd0, 2'd0)); settle();
    chk("R8 rank 0 hides layer", pix_out, 24'h008080);
    wr(3'd0, ctl(3'b000, 2'd3, 2'd0, 2'd0)); settle();
    chk("R8 enable clear hides layer", pix_out, 24'h008080);
  endtask

  task automatic t_video();
    defaults();
    vid_px = 24'h123456;
    wr(3'd0, ctl(3'b100, 2'd0, 2'd0, 2'd1)); settle();
    chk("R9 opaque video", pix_out, 24'h123456);
    wr(3'd4, 32'h8000_0000); settle();
    chk("R9 video layer alpha", pix_out, 24'h09596A);
    wr(3'd4, 32'hFFFF_0000);
    gfx_px[31:0] = 32'hFFFF_0000;
    wr(3'd0, ctl(3'b101, 2'd3, 2'd0, 2'd3)); settle();
    chk("R7 R9 video over graphics at tie", pix_out, 24'h123456);
  endtask

  task automatic t_latency();
    defaults();
    wr(3'd0, ctl(3'b001, 2'd1, 2'd0, 2'd0));
    gfx_px[31:0] = 32'hFF11_2233; settle();
    chk("R10 before change", pix_out, 24'h112233);
    gfx_px[31:0] = 32'hFF44_5566;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 old value after 3 clocks", pix_out, 24'h112233);
    @(posedge clk);
    @(negedge clk);
    chk("R10 new value after 4 clocks", pix_out, 24'h445566);
  endtask

  task automatic t_background();
    defaults();
    wr(3'd1, 32'h0011_2233); settle();
    chk("R11 R2 background write", pix_out, 24'h112233);
  endtask

  initial begin
    t_reset();
    t_formats();
    t_modes();
    t_window();
    t_priority();
    t_inactive();
    t_video();
    t_latency();
    t_background();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R10 got=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule